// File: doc/BRIEF.md
# YUV 4:2:2 Split Receive Packer

This block takes a stream of 8-bit 4:2:2 video samples, one per accepted beat, arriving in the repeating order V, Y, U, Y (V0 Y0 U0 Y1 V1 Y2 U1 Y3 ...). It gathers them into 32-bit words of four samples each. With splitting off, the words hold samples in arrival order. With splitting on, luma samples are packed only with luma and chroma samples only with chroma. A further sub-split setting gives V and U words of their own. The words go out either all on one primary stream or, in dual mode, with luma on the primary stream and chroma on a secondary stream. The output can then feed separate luma and chroma buffers.

Each output class (luma/mixed and chroma) has one holding register, which is also that class's output register. In single-stream split mode, the primary stream strictly alternates chroma and luma words, starting with chroma. A word that finishes early therefore waits in its holding register until the word before it has been transferred. Back-pressure follows from this. `in_ready` falls when the offered sample would finish a word whose holding register is still occupied. `in_ready` never depends on the output ready pins in the same cycle. An output keeps `valid` high and its data unchanged until its `ready` is seen high at a clock edge.

The four control pins are captured only while `enable` is low. Idling in this way also throws away any partly packed word and restarts the sample sequence at a V sample.

Top module: `yuv_split_packer`

## Requirements
- R1: While `rst_n` is low at a clock edge, both output valids clear and the sample position returns to V0; with `enable` low after reset, `in_ready` is low.
- R2: `cfg_split`, `cfg_subsplit`, `cfg_swap` and `cfg_dual` are loaded only on edges where `enable` is low; changing them while `enable` is high has no effect on the words produced; `in_ready` is low whenever `enable` is low.
- R3: In every word, lane 0 (bits 7:0) holds the first sample of the word's packing order and lane 3 (bits 31:24) the last.
- R4: With `cfg_split` = 0, each word is four consecutive samples in arrival order, sent on the primary stream; `cfg_dual`, `cfg_swap` and `cfg_subsplit` have no effect and `sec_valid` stays low.
- R5: With `cfg_split` = 1 and `cfg_subsplit` = 0, luma words are Y(4k)..Y(4k+3). Chroma words are V(2k) U(2k) V(2k+1) U(2k+1) when `cfg_swap` = 1, and U(2k) V(2k) U(2k+1) V(2k+1) when `cfg_swap` = 0.
- R6: With `cfg_split` = 1 and `cfg_subsplit` = 1, chroma words are V(4k)..V(4k+3) and U(4k)..U(4k+3), and `cfg_swap` has no effect.
- R7: With `cfg_split` = 1 and `cfg_dual` = 0, all words leave on the primary stream, alternating chroma and luma and starting with chroma. With sub-split the order is V0..V3, Y0..Y3, U0..U3, Y4..Y7.
- R8: With `cfg_split` = 1 and `cfg_dual` = 1, luma words leave on the primary stream and chroma words on the secondary stream, each in its own order and each stalled only by its own ready.
- R9: An output with `valid` high and `ready` low keeps `valid` and data unchanged on the next cycle. A sample is refused (`in_ready` low) when it would complete a word whose holding register is occupied. With the primary ready held low in split-off mode, exactly seven samples are accepted.
- R10: Dropping `enable` discards a partly packed word, and the next accepted sample is treated as V0.
- R11: Under random stalls on the input and both outputs, every expected word arrives exactly once and no extra word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run enable; low = idle, controls captured |
| cfg_split | input | 1 | Separate luma from chroma |
| cfg_subsplit | input | 1 | Separate V words from U words |
| cfg_swap | input | 1 | Chroma order in interleaved chroma words |
| cfg_dual | input | 1 | Chroma words on the secondary stream |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted this edge if valid |
| in_data | input | SAMPLE_W | Sample value |
| pri_valid | output | 1 | Primary word available |
| pri_ready | input | 1 | Primary consumer takes word |
| pri_data | output | 4*SAMPLE_W | Primary word |
| sec_valid | output | 1 | Secondary (chroma) word available |
| sec_ready | input | 1 | Secondary consumer takes word |
| sec_data | output | 4*SAMPLE_W | Secondary word |

## Verification
Several properties are checked on every cycle: output words stay stable while stalled, a holding register is never loaded while it is occupied and not draining, `in_ready` is low while idle, and no chroma word is produced with splitting off. Only the bench scenarios can show the behaviour that depends on sample content and order. This covers lane placement, the swap orders, the chroma/luma alternation on one stream, the routing across two streams, the discarding of a partial word on idle, and the exact number of samples accepted before back-pressure.

// File: rtl/ysp_pkg.sv
package ysp_pkg;
  localparam int LANES = 4;

  typedef struct packed {
    logic split;
    logic sub;
    logic swap;
    logic dual;
  } ysp_cfg_t;

  localparam int ACC_N    = 3;
  localparam int ACC_LUMA = 0;
  localparam int ACC_V    = 1;
  localparam int ACC_U    = 2;
endpackage

// File: rtl/ysp_lane_map.sv
// Decodes the position within the 16-sample cycle into the target
// accumulator, its byte lane and whether the sample completes a word.
module ysp_lane_map
  import ysp_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int LANE_W = 2
) (
  input  ysp_cfg_t          cfg,
  input  logic [CNT_W-1:0]  pos,
  output logic [ACC_N-1:0]  acc_sel,
  output logic [LANE_W-1:0] lane,
  output logic              done,
  output logic              to_chroma
);
  always_comb begin
    acc_sel   = '0;
    lane      = '0;
    done      = 1'b0;
    to_chroma = 1'b0;
    if (!cfg.split) begin
      // arrival order, everything on the luma/mixed path
      acc_sel[ACC_LUMA] = 1'b1;
      lane              = pos[1:0];
      done              = (pos[1:0] == 2'd3);
    end else if (pos[0]) begin
      // odd positions carry luma
      acc_sel[ACC_LUMA] = 1'b1;
      lane              = pos[2:1];
      done              = (pos[2:0] == 3'd7);
    end else if (!cfg.sub) begin
      // interleaved chroma word, swap picks V-first or U-first pairs
      acc_sel[ACC_V] = 1'b1;
      lane           = cfg.swap ? pos[2:1] : {pos[2], ~pos[1]};
      done           = (pos[2:0] == 3'd6);
      to_chroma      = 1'b1;
    end else begin
      // separate V and U words
      if (pos[1]) acc_sel[ACC_U] = 1'b1;
      else        acc_sel[ACC_V] = 1'b1;
      lane      = pos[3:2];
      done      = (pos[3:2] == 2'd3);
      to_chroma = 1'b1;
    end
  end
endmodule

// File: rtl/ysp_word_acc.sv
// Byte-lane accumulator; "merged" is the stored word with the incoming
// sample already placed in its lane, so a word can complete in one edge.
module ysp_word_acc #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 4,
  parameter int LANE_W   = 2
) (
  input  logic                      clk,
  input  logic                      wr,
  input  logic [LANE_W-1:0]         lane,
  input  logic [SAMPLE_W-1:0]       din,
  output logic [SAMPLE_W*LANES-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SAMPLE_W-1:0] slot_q;
    logic                hit;
    assign hit = (lane == LANE_W'(g));
    always_ff @(posedge clk) begin
      if (wr && hit) slot_q <= din;
    end
    assign merged[g*SAMPLE_W +: SAMPLE_W] = hit ? din : slot_q;
  end
endmodule

// File: rtl/ysp_hold.sv
// One finished word per class; doubles as the output register.
module ysp_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  logic [WORD_W-1:0] din,
  output logic              valid,
  output logic [WORD_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)    valid <= 1'b0;
    else if (load) valid <= 1'b1;
    else if (take) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end
endmodule

// File: rtl/yuv_split_packer.sv
module yuv_split_packer
  import ysp_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      cfg_split,
  input  logic                      cfg_subsplit,
  input  logic                      cfg_swap,
  input  logic                      cfg_dual,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SAMPLE_W-1:0]       in_data,
  output logic                      pri_valid,
  input  logic                      pri_ready,
  output logic [SAMPLE_W*LANES-1:0] pri_data,
  output logic                      sec_valid,
  input  logic                      sec_ready,
  output logic [SAMPLE_W*LANES-1:0] sec_data
);
  localparam int WORD_W = SAMPLE_W * LANES;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = LANE_W + 2;   // one full V/U sub-split cycle

  ysp_cfg_t            cfg_q;
  logic [CNT_W-1:0]    pos_q;
  logic                tok_chroma_q;   // single-stream: next word is chroma
  logic                accept;
  logic [ACC_N-1:0]    acc_sel;
  logic [LANE_W-1:0]   lane;
  logic                done;
  logic                to_chroma;
  logic                blocked;
  logic [WORD_W-1:0]   merged [ACC_N];
  logic [WORD_W-1:0]   word_done;
  logic                load_y, load_c;
  logic                take_y, take_c;
  logic                hy_v, hc_v;
  logic [WORD_W-1:0]   hy_d, hc_d;
  logic                single_split, dual_split;
  logic                pri_fire;

  // control capture and sample position
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      pos_q <= '0;
    end else if (!enable) begin
      cfg_q <= '{split: cfg_split, sub: cfg_subsplit, swap: cfg_swap, dual: cfg_dual};
      pos_q <= '0;
    end else if (accept) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  ysp_lane_map #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_map (
    .cfg       (cfg_q),
    .pos       (pos_q),
    .acc_sel   (acc_sel),
    .lane      (lane),
    .done      (done),
    .to_chroma (to_chroma)
  );

  // back-pressure only from held state, never from output ready
  assign blocked  = done && (to_chroma ? hc_v : hy_v);
  assign in_ready = enable && !blocked;
  assign accept   = in_valid && in_ready;

  for (genvar a = 0; a < ACC_N; a++) begin : g_acc
    ysp_word_acc #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .LANE_W(LANE_W)) u_acc (
      .clk    (clk),
      .wr     (accept && acc_sel[a]),
      .lane   (lane),
      .din    (in_data),
      .merged (merged[a])
    );
  end

  always_comb begin
    word_done = '0;
    for (int a = 0; a < ACC_N; a++) begin
      if (acc_sel[a]) word_done = word_done | merged[a];
    end
  end

  assign load_y = accept && done && !to_chroma;
  assign load_c = accept && done &&  to_chroma;

  ysp_hold #(.WORD_W(WORD_W)) u_hold_y (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_y),
    .take  (take_y),
    .din   (word_done),
    .valid (hy_v),
    .dout  (hy_d)
  );

  ysp_hold #(.WORD_W(WORD_W)) u_hold_c (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_c),
    .take  (take_c),
    .din   (word_done),
    .valid (hc_v),
    .dout  (hc_d)
  );

  // output routing
  assign single_split = cfg_q.split && !cfg_q.dual;
  assign dual_split   = cfg_q.split &&  cfg_q.dual;

  always_comb begin
    if (single_split && tok_chroma_q) begin
      pri_valid = hc_v;
      pri_data  = hc_d;
    end else begin
      pri_valid = hy_v;
      pri_data  = hy_d;
    end
  end

  assign sec_valid = dual_split && hc_v;
  assign sec_data  = hc_d;
  assign pri_fire  = pri_valid && pri_ready;

  assign take_y = pri_fire && !(single_split && tok_chroma_q);
  assign take_c = single_split ? (pri_fire && tok_chroma_q) : (sec_valid && sec_ready);

  always_ff @(posedge clk) begin
    if (!rst_n)                          tok_chroma_q <= 1'b1;
    else if (single_split && pri_fire)   tok_chroma_q <= !tok_chroma_q;
    else if (!enable && !hy_v && !hc_v)  tok_chroma_q <= 1'b1;
  end
endmodule

// File: rtl/ysp_checker.sv
module ysp_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              in_ready,
  input logic              pri_valid,
  input logic              pri_ready,
  input logic [WORD_W-1:0] pri_data,
  input logic              sec_valid,
  input logic              sec_ready,
  input logic [WORD_W-1:0] sec_data,
  input logic              cfg_split,
  input logic              hy_v,
  input logic              hc_v,
  input logic              load_y,
  input logic              load_c,
  input logic              take_y,
  input logic              take_c
);
  AST_PRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pri_valid && !pri_ready) |=> (pri_valid && $stable(pri_data))); // R9
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sec_valid && !sec_ready) |=> (sec_valid && $stable(sec_data))); // R9
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !in_ready); // R2
  AST_NO_OVERWRITE_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (hy_v && !take_y) |-> !load_y); // R9
  AST_NO_OVERWRITE_C: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_v && !take_c) |-> !load_c); // R9
  AST_SPLIT_OFF_NO_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_split |-> !load_c); // R4
endmodule

bind yuv_split_packer ysp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .in_ready  (in_ready),
  .pri_valid (pri_valid),
  .pri_ready (pri_ready),
  .pri_data  (pri_data),
  .sec_valid (sec_valid),
  .sec_ready (sec_ready),
  .sec_data  (sec_data),
  .cfg_split (cfg_q.split),
  .hy_v      (hy_v),
  .hc_v      (hc_v),
  .load_y    (load_y),
  .load_c    (load_c),
  .take_y    (take_y),
  .take_c    (take_c)
);

// File: tb/sim_yuv_split_packer.sv
module sim_yuv_split_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_split = 1'b0, cfg_subsplit = 1'b0, cfg_swap = 1'b0, cfg_dual = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        pri_valid, sec_valid;
  logic        pri_ready = 1'b1, sec_ready = 1'b1;
  logic [31:0] pri_data, sec_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [7:0]  stim[$];
  logic [31:0] pri_q[$];
  logic [31:0] sec_q[$];

  always #5 clk = ~clk;

  yuv_split_packer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_split(cfg_split), .cfg_subsplit(cfg_subsplit), .cfg_swap(cfg_swap), .cfg_dual(cfg_dual),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pri_valid(pri_valid), .pri_ready(pri_ready), .pri_data(pri_data),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_data(sec_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w4(input logic [7:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  function automatic logic [7:0] sval(input int run, input int i);
    return 8'((i * 37 + run * 11 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // drive stim, check every transfer against the expected queues
  task automatic pump(input bit stall, input string tag);
    int guard = 0;
    forever begin
      @(negedge clk);
      pri_ready = stall ? ($urandom % 4 != 0) : 1'b1;
      sec_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      if (stim.size() > 0 && (!stall || $urandom % 5 != 0)) begin
        in_valid = 1'b1;
        in_data  = stim[0];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (pri_valid && pri_ready) begin
        if (pri_q.size() == 0) chk(1'b0, {tag, " primary unexpected word"}, pri_data, 32'h0);
        else begin
          chk(pri_data === pri_q[0], {tag, " primary word"}, pri_data, pri_q[0]);
          pri_q.delete(0);
        end
      end
      if (sec_valid && sec_ready) begin
        if (sec_q.size() == 0) chk(1'b0, {tag, " secondary unexpected word"}, sec_data, 32'h0);
        else begin
          chk(sec_data === sec_q[0], {tag, " secondary word"}, sec_data, sec_q[0]);
          sec_q.delete(0);
        end
      end
      if (in_valid && in_ready) stim.delete(0);
      if (stim.size() == 0 && pri_q.size() == 0 && sec_q.size() == 0 && !pri_valid && !sec_valid) break;
      guard++;
      if (guard > 4000) begin
        chk(1'b0, {tag, " R11 stream stalled"}, 32'(pri_q.size() + sec_q.size()), 32'h0);
        break;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    pri_ready = 1'b1;
    sec_ready = 1'b1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable   = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R2 in_ready low while idle", 32'(in_ready), 32'h0);
  endtask

  task automatic run_config(input int run, input bit sp, input bit sb, input bit sw, input bit du, input bit stall);
    int b;
    logic [7:0] s[64];
    logic [31:0] cw, yw, vw, uw, y0, y1;
    string tag;
    go_idle();
    cfg_split = sp; cfg_subsplit = sb; cfg_swap = sw; cfg_dual = du;
    @(negedge clk);
    enable = 1'b1;
    // pins change while running: must be ignored (R2)
    cfg_split = ~sp; cfg_subsplit = ~sb; cfg_swap = ~sw; cfg_dual = ~du;
    if (!sp)       tag = "R3/R4/R2";
    else if (!sb)  tag = du ? "R5/R8/R2" : "R5/R7/R2";
    else           tag = du ? "R6/R8/R2" : "R6/R7/R2";
    for (int i = 0; i < 64; i++) begin
      s[i] = sval(run, i);
      stim.push_back(s[i]);
    end
    for (int g = 0; g < 4; g++) begin
      b = g * 16;
      if (!sp) begin
        for (int k = 0; k < 4; k++)
          pri_q.push_back(w4(s[b+4*k], s[b+4*k+1], s[b+4*k+2], s[b+4*k+3]));
      end else if (!sb) begin
        for (int h = 0; h < 16; h += 8) begin
          cw = sw ? w4(s[b+h], s[b+h+2], s[b+h+4], s[b+h+6])
                  : w4(s[b+h+2], s[b+h], s[b+h+6], s[b+h+4]);
          yw = w4(s[b+h+1], s[b+h+3], s[b+h+5], s[b+h+7]);
          if (du) begin sec_q.push_back(cw); pri_q.push_back(yw); end
          else    begin pri_q.push_back(cw); pri_q.push_back(yw); end
        end
      end else begin
        vw = w4(s[b], s[b+4], s[b+8], s[b+12]);
        uw = w4(s[b+2], s[b+6], s[b+10], s[b+14]);
        y0 = w4(s[b+1], s[b+3], s[b+5], s[b+7]);
        y1 = w4(s[b+9], s[b+11], s[b+13], s[b+15]);
        if (du) begin
          sec_q.push_back(vw); sec_q.push_back(uw);
          pri_q.push_back(y0); pri_q.push_back(y1);
        end else begin
          pri_q.push_back(vw); pri_q.push_back(y0);
          pri_q.push_back(uw); pri_q.push_back(y1);
        end
      end
    end
    pump(stall, tag);
    repeat (3) @(negedge clk);
    #1;
    chk(!pri_valid && !sec_valid, "R11 no extra word after run", 32'({pri_valid, sec_valid}), 32'h0);
  endtask

  initial begin
    int acc;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pri_valid == 1'b0, "R1 pri_valid after reset", 32'(pri_valid), 32'h0);
    chk(sec_valid == 1'b0, "R1 sec_valid after reset", 32'(sec_valid), 32'h0);
    chk(in_ready == 1'b0, "R1 in_ready low with enable low", 32'(in_ready), 32'h0);

    // sweep every control combination, with and without stalls
    for (int st = 0; st < 2; st++)
      for (int c = 0; c < 16; c++)
        run_config(st * 16 + c, c[3], c[2], c[1], c[0], st[0]);

    // R9: primary stalled in split-off mode, seven samples taken
    go_idle();
    cfg_split = 1'b0; cfg_subsplit = 1'b0; cfg_swap = 1'b0; cfg_dual = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 8; i++) stim.push_back(8'(8'h40 + i));
    pri_q.push_back(32'h43424140);
    pri_q.push_back(32'h47464544);
    acc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      pri_ready = 1'b0;
      in_valid  = (stim.size() > 0);
      in_data   = (stim.size() > 0) ? stim[0] : 8'h00;
      #1;
      if (in_valid && in_ready) begin stim.delete(0); acc++; end
    end
    chk(acc == 7, "R9 samples accepted under stall", 32'(acc), 32'd7);
    chk(in_ready == 1'b0, "R9 in_ready low when word would complete", 32'(in_ready), 32'h0);
    chk(pri_valid && pri_data == 32'h43424140, "R9 held word stable", pri_data, 32'h43424140);
    pump(1'b0, "R9");

    // R10: idle drops a partial word and restarts at V
    go_idle();
    @(negedge clk);
    enable = 1'b1;
    stim.push_back(8'hA0);
    stim.push_back(8'hA1);
    pump(1'b0, "R10 partial");
    go_idle();
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 4; i++) stim.push_back(8'(8'hB0 + i));
    pri_q.push_back(32'hB3B2B1B0);
    pump(1'b0, "R10 restart");
    chk(pri_q.size() == 0, "R10 restart word seen", 32'(pri_q.size()), 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule